// File: doc/BRIEF.md
# Strap-addressed I2C register slave

This block is an I2C target that gives an external bus master read and write access to a small on-chip register file. SCL and SDA are oversampled by the system clock through a synchroniser. The block detects start, repeated-start and stop conditions on the synchronised lines. It compares the first byte of each transfer against its own 7-bit bus address.

The four upper address bits are a fixed prefix, 1011b. The three lower bits come from two three-level strap pins, and one strap combination switches the I2C function off in favour of a separate SPI port.

After a write-addressed device byte, the master sends a 16-bit register pointer, high byte first. Any further bytes are stored at the pointer, which advances after each byte. A read-addressed device byte, usually issued after a repeated start, makes the block return bytes from the pointer until the master declines one. The block only drives SDA low through an open-drain enable and never touches SCL.

Top module: `i2c_strap_slave`

## Requirements
- R1: Each strap pin is given as a 2-bit level code: 00 low, 01 open, 10 high, with 11 read as open. With levels counted low=0, open=1, high=2, the three low address bits equal 3*level(msb strap)+level(lsb strap). The device address is {1011b, those 3 bits}, and spi_sel_o is 0 for every pair except high/high. The decoded address and spi_sel_o are registered one clock after the straps.
- R2: While both straps are high, spi_sel_o is 1 and the block acknowledges no byte and never drives SDA.
- R3: After reset, sda_oe_o is 0 and every register reads back as 0x00.
- R4: A start is a falling SDA edge while SCL is high, and a stop is a rising SDA edge while SCL is high. A start or repeated start always begins a new device-byte reception. A start or stop in the middle of a byte abandons that byte, and an abandoned write byte is not stored.
- R5: Bytes are taken MSB first, with bit 0 of the device byte being 1 for read. A device byte that matches the address is acknowledged by pulling SDA low during the ninth SCL pulse. A device byte that does not match is not acknowledged, and every later byte is ignored until the next start.
- R6: In a write transfer, the two bytes after the device byte load the register pointer, high byte first. Each following byte is written to the register at the pointer, and the pointer then increments. Each of these bytes is acknowledged.
- R7: In a read transfer, the block sends the register at the pointer MSB first. After each byte that the master acknowledges, the pointer increments and the next register is sent.
- R8: A master no-acknowledge ends the read: the block releases SDA and sends nothing more until the next start.
- R9: sda_oe_o changes only while SCL is low, so the SDA level driven by the block is constant for the whole SCL high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_msb_i | input | 2 | Upper strap level code |
| strap_lsb_i | input | 2 | Lower strap level code |
| spi_sel_o | output | 1 | 1 when the straps select the SPI port and I2C is off |

## Verification
The bench visits several strap pairs and checks that only the decoded address is acknowledged. A decoder with a wrong weight or a wrong prefix would acknowledge the old address or refuse the new one. It sets both straps high and expects silence on the bus, which catches a design that keeps acknowledging in SPI mode. It reads back through a repeated start across several registers, including one that was never written, so a pointer that skips or fails to advance gives wrong bytes. It also sends a stop halfway through a data byte and a stray byte after an address mismatch: a design that commits partial bytes or keeps listening after a mismatch alters the read-back or acknowledges where it must not.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_PTR_HI, ST_PTR_LO, ST_WR, ST_RD
  } i2cs_state_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_OPEN = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  // unused code 11 is read as open
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    return (code == 2'b11) ? LVL_OPEN : code;
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  logic scl_s;
  assign scl_s      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2cs_strap_dec.sv
module i2cs_strap_dec
  import i2cs_pkg::*;
#(
  parameter logic [3:0] PREFIX = 4'b1011
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] strap_msb_i,
  input  logic [1:0] strap_lsb_i,
  output logic [6:0] dev_addr_o,
  output logic       spi_sel_o
);
  logic [3:0] idx;
  assign idx = {2'b00, strap_level(strap_msb_i)} * 4'd3
             + {2'b00, strap_level(strap_lsb_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_addr_o <= {PREFIX, 3'b000};
      spi_sel_o  <= 1'b0;
    end else begin
      dev_addr_o <= {PREFIX, idx[2:0]};
      spi_sel_o  <= (idx == 4'd8);
    end
  end
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem[g] <= 8'h00;
      else if (we_i && waddr_i == IW'(g))          mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2cs_pkg::*;
#(
  parameter int         REG_DEPTH   = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b1011
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] strap_msb_i,
  input  logic [1:0] strap_lsb_i,
  output logic       spi_sel_o
);
  localparam int IW = $clog2(REG_DEPTH);

  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [6:0] dev_addr;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2cs_strap_dec #(.PREFIX(ADDR_PREFIX)) u_dec (
    .clk_i, .rst_ni, .strap_msb_i, .strap_lsb_i,
    .dev_addr_o(dev_addr), .spi_sel_o
  );

  i2cs_state_e state;
  logic [3:0]       bit_cnt;
  logic [7:0]       sh, tx;
  logic [PTR_W-1:0] ptr, ptr_nx;
  logic             rd, mnack, ack_drv, tx_act;
  logic             we, quiet;
  logic [7:0]       rdata;

  assign quiet  = spi_sel_o | stop_c | start_c;
  assign ptr_nx = ptr + 1'b1;
  assign we     = ~quiet & scl_fall & (bit_cnt == 4'd8) & (state == ST_WR);

  i2cs_regfile #(.DEPTH(REG_DEPTH)) u_rf (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(ptr[IW-1:0]), .wdata_i(sh),
    .raddr_i(state == ST_RD ? ptr_nx[IW-1:0] : ptr[IW-1:0]), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sh      <= '0;
      tx      <= '1;
      ptr     <= '0;
      rd      <= 1'b0;
      mnack   <= 1'b1;
      ack_drv <= 1'b0;
      tx_act  <= 1'b0;
    end else if (spi_sel_o || stop_c) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      ack_drv <= 1'b0;
      tx_act  <= 1'b0;
    end else if (start_c) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      ack_drv <= 1'b0;
      tx_act  <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < 4'd8) begin
          bit_cnt <= bit_cnt + 4'd1;
          sh      <= {sh[6:0], sda_s};
        end else if (bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          mnack   <= sda_s;
        end
      end else if (scl_fall) begin
        if (bit_cnt == 4'd8) begin
          unique case (state)
            ST_DEV: begin
              if (sh[7:1] == dev_addr) begin
                ack_drv <= 1'b1;
                rd      <= sh[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_PTR_HI: begin ack_drv <= 1'b1; ptr[15:8] <= sh; end
            ST_PTR_LO: begin ack_drv <= 1'b1; ptr[7:0]  <= sh; end
            ST_WR:     begin ack_drv <= 1'b1; ptr <= ptr_nx;   end
            ST_RD:     tx_act <= 1'b0;
            default:   ;
          endcase
        end else if (bit_cnt == 4'd9) begin
          bit_cnt <= '0;
          ack_drv <= 1'b0;
          unique case (state)
            ST_DEV: begin
              if (rd) begin
                state  <= ST_RD;
                tx     <= rdata;
                tx_act <= 1'b1;
              end else begin
                state <= ST_PTR_HI;
              end
            end
            ST_PTR_HI: state <= ST_PTR_LO;
            ST_PTR_LO: state <= ST_WR;
            ST_RD: begin
              if (mnack) begin
                state <= ST_IDLE;
              end else begin
                ptr    <= ptr_nx;
                tx     <= rdata;
                tx_act <= 1'b1;
              end
            end
            default: ;
          endcase
        end else if (bit_cnt != 4'd0 && state == ST_RD) begin
          tx <= {tx[6:0], 1'b1};
        end
      end
    end
  end

  assign sda_oe_o = ack_drv | (tx_act & ~tx[7]);
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic [1:0] strap_msb_i,
  input logic [1:0] strap_lsb_i,
  input logic       spi_sel_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_quiet_r3: assert (!sda_oe_o && !spi_sel_o)
        else $error("R3 outputs active in reset");
    end
  end

  p_spi_decode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_msb_i == 2'b10 && strap_lsb_i == 2'b10) |=> spi_sel_o);

  p_i2c_decode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_msb_i != 2'b10 || strap_lsb_i != 2'b10) |=> !spi_sel_o);

  p_spi_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sel_o |=> !sda_oe_o);

  p_sda_change_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_strap_slave i2cs_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .strap_msb_i(strap_msb_i), .strap_lsb_i(strap_lsb_i), .spi_sel_o(spi_sel_o)
);

// File: tb/tb_i2c_strap_slave.sv
module tb_i2c_strap_slave;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] s_msb = 2'b00, s_lsb = 2'b00;
  logic sda_oe, spi_sel;
  logic sda_bus;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_strap_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_msb_i(s_msb), .strap_lsb_i(s_lsb),
    .spi_sel_o(spi_sel)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       rd_ev;

  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) begin
      check("R7 unexpected byte", obs, 8'hxx);
    end else begin
      check(tag_q.pop_front(), obs, exp_q.pop_front());
    end
  end

  task automatic expect_byte(string tag, logic [7:0] b);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    wq(); sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    logic oe0;
    wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq();
    b = sda_bus; oe0 = sda_oe; wq();
    check("R9 sda stable in high", {7'd0, sda_oe}, {7'd0, oe0});
    scl = 1'b0;
  endtask

  task automatic i2c_start();
    wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0;
  endtask

  task automatic i2c_stop();
    wq(); sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic rd_byte(logic master_ack);
    logic [7:0] v;
    logic bb;
    for (int i = 7; i >= 0; i--) begin bit_in(bb); v[i] = bb; end
    bit_out(~master_ack);
    obs = v;
    ->rd_ev;
    @(negedge clk);
  endtask

  task automatic send_ack(string req, logic [7:0] b, logic exp_ack);
    logic a;
    wr_byte(b, a);
    check(req, {7'd0, a}, {7'd0, exp_ack});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R3 sda_oe in reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    check("R1 spi_sel low/low", {7'd0, spi_sel}, 8'h00);

    // R6 write two bytes at 0x0003, address 0x58
    i2c_start();
    send_ack("R5 addr 58 write", 8'hB0, 1'b1);
    send_ack("R6 ptr hi", 8'h00, 1'b1);
    send_ack("R6 ptr lo", 8'h03, 1'b1);
    send_ack("R6 data0", 8'hA5, 1'b1);
    send_ack("R6 data1", 8'h3C, 1'b1);
    i2c_stop();

    // R7 read via repeated start from 0x0002
    i2c_start();
    send_ack("R5 addr write", 8'hB0, 1'b1);
    send_ack("R6 ptr hi", 8'h00, 1'b1);
    send_ack("R6 ptr lo", 8'h02, 1'b1);
    i2c_start();
    send_ack("R4 repeated start addr read", 8'hB1, 1'b1);
    expect_byte("R3 reset value reg2", 8'h00);
    expect_byte("R7 reg3", 8'hA5);
    expect_byte("R7 reg4 after increment", 8'h3C);
    rd_byte(1'b1);
    rd_byte(1'b1);
    rd_byte(1'b0);
    repeat (4) @(negedge clk);
    check("R8 released after nack", {7'd0, sda_oe}, 8'h00);
    begin
      logic b;
      bit_in(b);
      check("R8 no bits after nack", {7'd0, b}, 8'h01);
    end
    i2c_stop();

    // R5 mismatch
    i2c_start();
    send_ack("R5 mismatch 5A", 8'hB4, 1'b0);
    send_ack("R5 ignored after mismatch", 8'h00, 1'b0);
    i2c_stop();

    // R1 open/high -> 0x5D
    s_msb = 2'b01; s_lsb = 2'b10;
    repeat (4) @(negedge clk);
    check("R1 spi_sel open/high", {7'd0, spi_sel}, 8'h00);
    i2c_start();
    send_ack("R1 old address refused", 8'hB0, 1'b0);
    i2c_stop();
    i2c_start();
    send_ack("R1 addr 5D", 8'hBA, 1'b1);
    send_ack("R6 ptr hi", 8'h00, 1'b1);
    send_ack("R6 ptr lo", 8'h0A, 1'b1);
    send_ack("R6 data", 8'h77, 1'b1);
    i2c_start();
    send_ack("R1 addr 5D write", 8'hBA, 1'b1);
    send_ack("R6 ptr hi", 8'h00, 1'b1);
    send_ack("R6 ptr lo", 8'h0A, 1'b1);
    i2c_start();
    send_ack("R1 addr 5D read", 8'hBB, 1'b1);
    expect_byte("R7 reg A", 8'h77);
    rd_byte(1'b0);
    i2c_stop();

    // R1 high/open -> 0x5F, code 11 read as open
    s_msb = 2'b10; s_lsb = 2'b11;
    repeat (4) @(negedge clk);
    i2c_start();
    send_ack("R1 addr 5F", 8'hBE, 1'b1);
    i2c_stop();

    // R2 spi mode
    s_msb = 2'b10; s_lsb = 2'b10;
    repeat (4) @(negedge clk);
    check("R2 spi_sel high/high", {7'd0, spi_sel}, 8'h01);
    i2c_start();
    send_ack("R2 no ack 58", 8'hB0, 1'b0);
    i2c_stop();
    i2c_start();
    send_ack("R2 no ack 5F", 8'hBE, 1'b0);
    i2c_stop();

    // R4 stop mid data byte
    s_msb = 2'b00; s_lsb = 2'b00;
    repeat (4) @(negedge clk);
    check("R1 spi_sel cleared", {7'd0, spi_sel}, 8'h00);
    i2c_start();
    send_ack("R5 addr", 8'hB0, 1'b1);
    send_ack("R6 ptr hi", 8'h00, 1'b1);
    send_ack("R6 ptr lo", 8'h05, 1'b1);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
    i2c_stop();
    i2c_start();
    send_ack("R4 addr after abort", 8'hB0, 1'b1);
    send_ack("R6 ptr hi", 8'h00, 1'b1);
    send_ack("R6 ptr lo", 8'h05, 1'b1);
    i2c_start();
    send_ack("R4 read after abort", 8'hB1, 1'b1);
    expect_byte("R4 aborted byte not stored", 8'h00);
    rd_byte(1'b0);
    i2c_stop();

    repeat (10) @(negedge clk);
    check("R7 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule